// File: doc/BRIEF.md
# Coarse-Fine Quadrature Sine Generator

This block turns a phase word into a pair of signed samples, sine and cosine, for a numerically controlled oscillator. It keeps the error from phase truncation low without needing one huge table. The phase word has two parts. The upper bits index a coarse full-cycle sine table, which has two read ports. One port gives the sine of the coarse angle. The other port reads a quarter turn ahead and gives its cosine.

The lower bits index a much smaller table that holds the sine of the residual angle. Because the residual angle is always tiny, its cosine is treated as exactly one. Two multiplies and two adds then refine the coarse pair. Both tables are computed as constants when the design is elaborated.

The data path has three register stages:
- the table reads;
- the two rounded products;
- the saturating add and subtract.

An accompanying valid flag travels through the same three stages.

Top module: `cf_quad_sine`

## Requirements
- R1: All PHASE_W phase bits take part: with the defaults, coarse index A = phase_i[15:6] and fine index B = phase_i[5:0]. A nonzero B moves the outputs off the coarse table value whenever the true result differs from it by more than 6 LSB.
- R2: sin_o is within 3 LSB of 32767·sin(2π·p/65536), formed as sinA + round(cosA·sinB).
- R3: cos_o is within 3 LSB of 32767·cos(2π·p/65536), formed as cosA − round(sinA·sinB).
- R4: When B = 0, the outputs equal coarse table entries exactly. Entry k of the coarse table is round(32767·sin(2π·k/1024)). sin_o uses entry A, and cos_o uses entry (A + 256) mod 1024.
- R5: valid_o equals the valid_i sampled three rising edges earlier, and the data on that cycle belongs to that phase.
- R6: Sums saturate to the range −32768..32767 and never wrap. Over a full sweep, no output reaches −32768, and each output's sign matches the reference whenever the reference magnitude exceeds 8 LSB.
- R7: While rst_ni is low, valid_o, sin_o and cos_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Phase word is valid this cycle |
| phase_i | input | PHASE_W | Phase word, one full turn over 2^PHASE_W |
| valid_o | output | 1 | Output samples valid |
| sin_o | output | OUT_W | Signed sine sample |
| cos_o | output | OUT_W | Signed cosine sample |

## Verification
A phase presented on a rising edge appears on sin_o and cos_o just after the third rising edge, counting the one that captured it. valid_o follows the same path. The bench drives inputs on falling edges and keeps a four-entry history of what it drove. At each falling edge it compares the outputs against the entry from three drives earlier, so every check lands on the cycle when that result is due. It sweeps every phase back to back, then runs a gapped, scattered pattern to confirm that the valid flag and the data stay aligned.

// File: rtl/cfqs_pkg.sv
package cfqs_pkg;
  parameter real TWO_PI = 6.283185307179586;
endpackage

// File: rtl/cfqs_coarse_rom.sv
module cfqs_coarse_rom import cfqs_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_s_i,
  input  logic [ADDR_W-1:0]        addr_c_i,
  output logic signed [DATA_W-1:0] sin_o,
  output logic signed [DATA_W-1:0] cos_o
);
  localparam int  DEPTH = 1 << ADDR_W;
  localparam real AMP   = real'((1 << (DATA_W-1)) - 1);

  logic signed [DATA_W-1:0] tbl [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tbl
    localparam real ANG = TWO_PI * real'(k) / real'(DEPTH);
    localparam int  VAL = $rtoi($floor(AMP * $sin(ANG) + 0.5));
    assign tbl[k] = DATA_W'(VAL);
  end

  // dual read port: same table, second address a quarter turn ahead
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sin_o <= '0;
      cos_o <= '0;
    end else begin
      sin_o <= tbl[addr_s_i];
      cos_o <= tbl[addr_c_i];
    end
  end
endmodule

// File: rtl/cfqs_fine_rom.sv
module cfqs_fine_rom import cfqs_pkg::*; #(
  parameter int ADDR_W  = 6,
  parameter int PHASE_W = 16,
  parameter int DATA_W  = 16,
  parameter int FRAC_Q  = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int  DEPTH = 1 << ADDR_W;
  localparam real SCALE = real'(64'd1 << FRAC_Q);

  logic [DATA_W-1:0] tbl [DEPTH];

  // sin of the residual angle, unsigned, scaled by 2^FRAC_Q
  for (genvar k = 0; k < DEPTH; k++) begin : g_tbl
    localparam real ANG = TWO_PI * real'(k) / real'(64'd1 << PHASE_W);
    localparam int  VAL = $rtoi($floor(SCALE * $sin(ANG) + 0.5));
    assign tbl[k] = DATA_W'(VAL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= tbl[addr_i];
  end
endmodule

// File: rtl/cfqs_mul_round.sv
module cfqs_mul_round #(
  parameter int CW = 16,
  parameter int FW = 16,
  parameter int Q  = 22
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [CW-1:0] coef_i,
  input  logic [FW-1:0]        frac_i,
  output logic signed [CW-1:0] prod_o
);
  localparam int PW = CW + FW + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (Q-1);

  logic signed [PW-1:0] full;
  logic signed [PW-1:0] rnd;

  assign full = coef_i * $signed({1'b0, frac_i});
  assign rnd  = full + HALF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prod_o <= '0;
    else         prod_o <= CW'(rnd >>> Q);
  end

  // R2/R3: fine factor is below one, so the product stays between 0 and the coefficient
  a_r2_prod_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(coef_i) >= 0) |-> (prod_o >= 0 && prod_o <= $past(coef_i)));
  a_r3_prod_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(coef_i) < 0) |-> (prod_o <= 0 && prod_o >= $past(coef_i)));
endmodule

// File: rtl/cf_quad_sine.sv
module cf_quad_sine #(
  parameter int PHASE_W  = 16,
  parameter int COARSE_W = 10,
  parameter int OUT_W    = 16,
  parameter int FINE_DW  = 16,
  parameter int FINE_Q   = 22
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [PHASE_W-1:0]      phase_i,
  output logic                    valid_o,
  output logic signed [OUT_W-1:0] sin_o,
  output logic signed [OUT_W-1:0] cos_o
);
  localparam int FINE_W = PHASE_W - COARSE_W;
  localparam logic [COARSE_W-1:0] QTR = COARSE_W'(1) << (COARSE_W-2);
  localparam logic signed [OUT_W:0] MAXV = (OUT_W+1)'((1 << (OUT_W-1)) - 1);
  localparam logic signed [OUT_W:0] MINV = -(OUT_W+1)'(1 << (OUT_W-1));

  logic [COARSE_W-1:0]      a_idx;
  logic [FINE_W-1:0]        b_idx;
  logic signed [OUT_W-1:0]  sin_a1, cos_a1, sin_a2, cos_a2;
  logic [FINE_DW-1:0]       sin_b1;
  logic signed [OUT_W-1:0]  coef [2];
  logic signed [OUT_W-1:0]  prod [2];
  logic [2:0]               v_q;
  logic signed [OUT_W:0]    sum_s, dif_c;

  assign a_idx = phase_i[PHASE_W-1 -: COARSE_W];
  assign b_idx = phase_i[FINE_W-1:0];

  // stage 1: table reads
  cfqs_coarse_rom #(.ADDR_W(COARSE_W), .DATA_W(OUT_W)) u_coarse (
    .clk_i, .rst_ni,
    .addr_s_i(a_idx), .addr_c_i(a_idx + QTR),
    .sin_o(sin_a1), .cos_o(cos_a1)
  );

  cfqs_fine_rom #(.ADDR_W(FINE_W), .PHASE_W(PHASE_W), .DATA_W(FINE_DW), .FRAC_Q(FINE_Q)) u_fine (
    .clk_i, .rst_ni, .addr_i(b_idx), .data_o(sin_b1)
  );

  // stage 2: cosA*sinB feeds sine, sinA*sinB feeds cosine
  assign coef[0] = cos_a1;
  assign coef[1] = sin_a1;

  for (genvar i = 0; i < 2; i++) begin : g_mul
    cfqs_mul_round #(.CW(OUT_W), .FW(FINE_DW), .Q(FINE_Q)) u_mul (
      .clk_i, .rst_ni, .coef_i(coef[i]), .frac_i(sin_b1), .prod_o(prod[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sin_a2 <= '0;
      cos_a2 <= '0;
    end else begin
      sin_a2 <= sin_a1;
      cos_a2 <= cos_a1;
    end
  end

  // stage 3: add/subtract with saturation
  assign sum_s = {sin_a2[OUT_W-1], sin_a2} + {prod[0][OUT_W-1], prod[0]};
  assign dif_c = {cos_a2[OUT_W-1], cos_a2} - {prod[1][OUT_W-1], prod[1]};

  function automatic logic signed [OUT_W-1:0] sat(input logic signed [OUT_W:0] x);
    if (x > MAXV)      return OUT_W'(MAXV);
    else if (x < MINV) return OUT_W'(MINV);
    else               return OUT_W'(x);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sin_o <= '0;
      cos_o <= '0;
      v_q   <= '0;
    end else begin
      sin_o <= sat(sum_s);
      cos_o <= sat(dif_c);
      v_q   <= {v_q[1:0], valid_i};
    end
  end

  assign valid_o = v_q[2];

  a_r5_valid_lat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, 3));
  a_r6_sin_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sin_a2 >= 0 && prod[0] >= 0) |=> (sin_o >= 0));
  a_r6_cos_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cos_a2 <= 0 && prod[1] >= 0) |=> (cos_o <= 0));
endmodule

// File: tb/cf_quad_sine_tb.sv
module cf_quad_sine_tb;
  localparam real TWO_PI = 6.283185307179586;
  localparam real AMP    = 32767.0;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               valid_i = 1'b0;
  logic [15:0]        phase_i = '0;
  logic               valid_o;
  logic signed [15:0] sin_o, cos_o;

  int   errors = 0;
  int   checks = 0;
  int   cyc = 0;
  bit   done = 1'b0;
  logic        hv [4] = '{default: 1'b0};
  logic [15:0] hp [4] = '{default: 16'd0};

  always #2ns clk_i = ~clk_i;

  cf_quad_sine u_dut (
    .clk_i, .rst_ni, .valid_i, .phase_i, .valid_o, .sin_o, .cos_o
  );

  function automatic int coarse(input int k);
    return $rtoi($floor(AMP * $sin(TWO_PI * real'(k % 1024) / 1024.0) + 0.5));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_out();
    int idx = (cyc + 2) & 3;
    logic [15:0] p = hp[idx];
    real rs, rc;
    int a, b, s, c;
    chk(valid_o == hv[idx], "R5 valid latency", int'(valid_o), int'(hv[idx]));
    if (hv[idx]) begin
      a  = int'(p[15:6]);
      b  = int'(p[5:0]);
      s  = int'(sin_o);
      c  = int'(cos_o);
      rs = AMP * $sin(TWO_PI * real'(p) / 65536.0);
      rc = AMP * $cos(TWO_PI * real'(p) / 65536.0);
      chk(((real'(s) - rs) <= 3.0) && ((rs - real'(s)) <= 3.0), "R2 sine accuracy", s, $rtoi(rs));
      chk(((real'(c) - rc) <= 3.0) && ((rc - real'(c)) <= 3.0), "R3 cosine accuracy", c, $rtoi(rc));
      chk(s != -32768 && !(rs > 8.0 && s < 0) && !(rs < -8.0 && s > 0), "R6 sine no wrap", s, $rtoi(rs));
      chk(c != -32768 && !(rc > 8.0 && c < 0) && !(rc < -8.0 && c > 0), "R6 cosine no wrap", c, $rtoi(rc));
      if (b == 0) begin
        chk(s == coarse(a), "R4 sine coarse entry", s, coarse(a));
        chk(c == coarse(a + 256), "R4 cosine quarter-turn entry", c, coarse(a + 256));
      end
      if (b == 32 && ((rs - real'(coarse(a))) > 6.0 || (real'(coarse(a)) - rs) > 6.0))
        chk(s != coarse(a), "R1 fine bits used", s, coarse(a));
    end
  endtask

  task automatic step(input logic v, input logic [15:0] p);
    @(negedge clk_i);
    check_out();
    cyc++;
    hv[cyc & 3] = v;
    hp[cyc & 3] = p;
    valid_i = v;
    phase_i = p;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0, "R7 reset valid", int'(valid_o), 0);
    chk(sin_o == 0, "R7 reset sine", int'(sin_o), 0);
    chk(cos_o == 0, "R7 reset cosine", int'(cos_o), 0);
    rst_ni = 1'b1;
    // full sweep, back to back
    for (int i = 0; i < 65536; i++) step(1'b1, 16'(i));
    // gapped, scattered phases
    for (int i = 0; i < 300; i++) step((i % 3) != 0, 16'(i * 977 + 13));
    for (int i = 0; i < 4; i++) step(1'b0, 16'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule